// File: doc/BRIEF.md
# Master-clock ratio detector and power-up sequencer

This block runs on the converter's master clock and watches the incoming frame clock, the signal that marks left and right sample slots. While the frame clock is absent it keeps the converter in power-down: modulator held in reset, reference, converter and output stages disabled. Once frame-clock rising edges arrive, it counts master-clock cycles across one frame period and maps the count onto one of ten supported master-to-frame ratios. A count that fits no supported ratio raises an error flag, and the block stays powered down.

After a good measurement the block turns on the voltage reference. After a fixed ramp time it enables the converter and filters and releases the modulator reset. It then keeps the audio muted for a programmable number of frame periods; the default is 2000. If the frame clock stops for longer than a timeout counted in master-clock cycles, everything falls back to power-down.

A second function filters a shared control pin into a de-emphasis enable. The pin level is sampled on each frame-clock falling edge. Five equal samples in a row set the enable (low level) or clear it (high level). The pin is honoured only when the block is told that the bit clock is generated internally.

Top module: `mclk_ratio_sequencer`

## Requirements
- R1: During and right after reset, refEn, convEn, modRstN, audioUnmute, ratioErr and deemphEn are 0 and ratioCode is 0.
- R2: While frameClk shows no rising edge, the block stays powered down (refEn=0, ratioCode=0).
- R3: A frame period that lies within TOL cycles of a supported ratio is latched as ratioCode, encoded 1=64, 2=96, 3=128, 4=192, 5=256, 6=384, 7=512, 8=768, 9=1024, 10=1152. While refEn is 1, ratioCode is one of 1..10.
- R4: A frame period farther than TOL from every supported ratio sets ratioErr=1 and keeps refEn=0 and ratioCode=0. ratioErr is never 1 while refEn is 1.
- R5: refEn rises first. convEn and modRstN rise together exactly REF_CYCLES master-clock cycles after refEn, and convEn is never 1 without refEn.
- R6: audioUnmute rises CONV_CYCLES cycles plus MUTE_FRAMES frame periods after convEn, within one frame period of slack, and is never 1 without convEn.
- R7: When frameClk has no rising edge for more than LOSS_LIMIT cycles, all enables drop to 0, ratioCode returns to 0 and ratioErr clears.
- R8: With intBitClkMode=1, emphCtrlIn sampled low on DEM_EDGES (5) consecutive frameClk falling edges sets deemphEn. Sampled high on 5 consecutive falling edges, it clears deemphEn. A shorter run, or a run broken by the other level, changes nothing.
- R9: With intBitClkMode=0, deemphEn is 0 from the next cycle on, whatever emphCtrlIn does. The filter history restarts when internal mode returns.
- R10: The tolerance edges are inclusive: periods of exactly ratio−TOL and ratio+TOL lock, and ratio+TOL+1 is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic runs on it |
| rst_n | input | 1 | Active-low synchronous reset |
| frameClk | input | 1 | Frame (left/right) clock, asynchronous to clk |
| emphCtrlIn | input | 1 | Shared de-emphasis control / bit-clock pin level |
| intBitClkMode | input | 1 | 1 = bit clock derived internally, de-emphasis pin honoured |
| ratioCode | output | 4 | Locked ratio index, 0 = none |
| ratioErr | output | 1 | Last measured period matched no supported ratio |
| refEn | output | 1 | Voltage reference enable |
| convEn | output | 1 | Converter and switched-capacitor filter enable |
| modRstN | output | 1 | Modulator and interpolator reset release (active high) |
| audioUnmute | output | 1 | Audio output allowed |
| deemphEn | output | 1 | Filtered de-emphasis enable |

## Verification
The bench steps through every supported ratio. Each one is driven at the lower tolerance edge, the centre or the upper edge, so a classifier with an off-by-one window, a swapped code or a counter that starts at zero instead of one locks to the wrong code or rejects the period. Between ratios the frame clock is stopped, which makes the block recover from the timeout. A design that missed the timeout, or that kept a stale code or error flag, would show enables or a code that never return to zero.

Periods just outside the window and between two ratios must raise the error flag without powering anything. A design that treated near-misses as hits would turn on the reference. The de-emphasis filter gets runs of four and five samples, a run broken by one opposite sample, and a switch to external bit-clock mode followed by a return. A filter that counted non-consecutive samples, or kept its history across the mode change, would toggle one frame early.

// File: rtl/ratio_seq_pkg.sv
package ratio_seq_pkg;

  localparam int NUM_RATIOS = 10;

  typedef enum logic [2:0] {
    ST_PDN,
    ST_MEAS,
    ST_REF,
    ST_CONV,
    ST_MUTE,
    ST_RUN
  } seqState_t;

  // datapath -> control
  typedef struct packed {
    logic lrRise;
    logic ratioHit;
    logic lost;
  } dpStatus_t;

  // control -> datapath
  typedef struct packed {
    logic latchRatio;
    logic flagErr;
    logic clearAll;
  } ctrlStrobe_t;

  // master cycles per frame for each supported ratio, ascending
  function automatic int ratioOf(input int idx);
    int base;
    int pow;
    pow  = idx / 2;
    base = (idx % 2 == 0) ? 64 : 96;
    if (idx == NUM_RATIOS - 1) return 1152;
    return base << pow;
  endfunction

endpackage

// File: rtl/ratio_seq_dp.sv
module ratio_seq_dp
  import ratio_seq_pkg::*;
#(
  parameter int TOL        = 2,
  parameter int LOSS_LIMIT = 2304,
  parameter int DEM_EDGES  = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frameClk,
  input  logic        emphCtrlIn,
  input  logic        intBitClkMode,
  input  ctrlStrobe_t cmd,
  output dpStatus_t   stat,
  output logic [3:0]  ratioCode,
  output logic        ratioErr,
  output logic        deemphEn
);

  localparam int CNT_W = $clog2(LOSS_LIMIT + 1) + 1;
  localparam int DW    = $clog2(DEM_EDGES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // two-flop synchronizer plus one history flop for edge detection
  logic [2:0] lrSync;
  logic [1:0] demSync;
  logic       lrRise, lrFall, demSample;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lrSync  <= '0;
      demSync <= '1;
    end else begin
      lrSync  <= {lrSync[1:0], frameClk};
      demSync <= {demSync[0], emphCtrlIn};
    end
  end

  assign lrRise    = lrSync[1] & ~lrSync[2];
  assign lrFall    = ~lrSync[1] & lrSync[2];
  assign demSample = demSync[1];

  // cycles since the last rising edge; equals the period at the next edge
  logic [CNT_W-1:0] periodCnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                   periodCnt <= '0;
    else if (lrRise)              periodCnt <= CNT_W'(1);
    else if (periodCnt != CNT_MAX) periodCnt <= periodCnt + 1'b1;
  end

  // window match against every supported ratio
  logic [NUM_RATIOS-1:0] hitVec;
  logic [3:0]            hitCode;

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
    localparam int RVAL = ratioOf(g);
    assign hitVec[g] = (periodCnt >= CNT_W'(RVAL - TOL)) &&
                       (periodCnt <= CNT_W'(RVAL + TOL));
  end

  always_comb begin
    hitCode = '0;
    for (int k = 0; k < NUM_RATIOS; k++) begin
      if (hitVec[k]) hitCode = 4'(k + 1);
    end
  end

  assign stat.lrRise   = lrRise;
  assign stat.ratioHit = |hitVec;
  assign stat.lost     = (periodCnt >= CNT_W'(LOSS_LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n || cmd.clearAll) begin
      ratioCode <= '0;
      ratioErr  <= 1'b0;
    end else if (cmd.latchRatio) begin
      ratioCode <= hitCode;
      ratioErr  <= 1'b0;
    end else if (cmd.flagErr) begin
      ratioErr  <= 1'b1;
    end
  end

  // de-emphasis run-length filter on frame falling edges
  logic          lastLvl;
  logic [DW-1:0] runCnt, newCnt;

  always_comb begin
    if (demSample != lastLvl)             newCnt = DW'(1);
    else if (runCnt == DW'(DEM_EDGES))    newCnt = runCnt;
    else                                  newCnt = runCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !intBitClkMode) begin
      lastLvl  <= 1'b1;
      runCnt   <= '0;
      deemphEn <= 1'b0;
    end else if (lrFall) begin
      lastLvl <= demSample;
      runCnt  <= newCnt;
      if (newCnt == DW'(DEM_EDGES)) deemphEn <= ~demSample;
    end
  end

endmodule

// File: rtl/ratio_seq_ctrl.sv
module ratio_seq_ctrl
  import ratio_seq_pkg::*;
#(
  parameter int REF_CYCLES  = 4096,
  parameter int CONV_CYCLES = 4096,
  parameter int MUTE_FRAMES = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  dpStatus_t   stat,
  output ctrlStrobe_t cmd,
  output logic        refEn,
  output logic        convEn,
  output logic        modRstN,
  output logic        audioUnmute
);

  localparam int SEQ_MAX = (REF_CYCLES > CONV_CYCLES) ? REF_CYCLES : CONV_CYCLES;
  localparam int SEQ_W   = $clog2(SEQ_MAX + 1);
  localparam int FRM_W   = $clog2(MUTE_FRAMES + 1);

  seqState_t        state, nextState;
  logic [SEQ_W-1:0] seqCnt;
  logic [FRM_W-1:0] frameCnt;

  always_comb begin
    nextState = state;
    cmd       = '0;
    unique case (state)
      ST_PDN:  if (stat.lrRise) nextState = ST_MEAS;
      ST_MEAS: begin
        if (stat.lost) begin
          nextState    = ST_PDN;
          cmd.clearAll = 1'b1;
        end else if (stat.lrRise) begin
          if (stat.ratioHit) begin
            nextState      = ST_REF;
            cmd.latchRatio = 1'b1;
          end else begin
            cmd.flagErr = 1'b1;
          end
        end
      end
      ST_REF, ST_CONV, ST_MUTE, ST_RUN: begin
        if (stat.lost) begin
          nextState    = ST_PDN;
          cmd.clearAll = 1'b1;
        end else if (state == ST_REF && seqCnt == SEQ_W'(REF_CYCLES - 1)) begin
          nextState = ST_CONV;
        end else if (state == ST_CONV && seqCnt == SEQ_W'(CONV_CYCLES - 1)) begin
          nextState = ST_MUTE;
        end else if (state == ST_MUTE && stat.lrRise &&
                     frameCnt == FRM_W'(MUTE_FRAMES - 1)) begin
          nextState = ST_RUN;
        end
      end
      default: nextState = ST_PDN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_PDN;
      seqCnt   <= '0;
      frameCnt <= '0;
    end else begin
      state <= nextState;
      if (nextState != state) begin
        seqCnt   <= '0;
        frameCnt <= '0;
      end else begin
        if (state == ST_REF || state == ST_CONV) seqCnt <= seqCnt + 1'b1;
        if (state == ST_MUTE && stat.lrRise)     frameCnt <= frameCnt + 1'b1;
      end
    end
  end

  assign refEn       = (state == ST_REF) || (state == ST_CONV) ||
                       (state == ST_MUTE) || (state == ST_RUN);
  assign convEn      = (state == ST_CONV) || (state == ST_MUTE) || (state == ST_RUN);
  assign modRstN     = convEn;
  assign audioUnmute = (state == ST_RUN);

endmodule

// File: rtl/mclk_ratio_sequencer.sv
module mclk_ratio_sequencer
  import ratio_seq_pkg::*;
#(
  parameter int TOL         = 2,
  parameter int LOSS_LIMIT  = 2304,
  parameter int DEM_EDGES   = 5,
  parameter int REF_CYCLES  = 4096,
  parameter int CONV_CYCLES = 4096,
  parameter int MUTE_FRAMES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frameClk,
  input  logic       emphCtrlIn,
  input  logic       intBitClkMode,
  output logic [3:0] ratioCode,
  output logic       ratioErr,
  output logic       refEn,
  output logic       convEn,
  output logic       modRstN,
  output logic       audioUnmute,
  output logic       deemphEn
);

  dpStatus_t   stat;
  ctrlStrobe_t cmd;

  ratio_seq_dp #(
    .TOL(TOL), .LOSS_LIMIT(LOSS_LIMIT), .DEM_EDGES(DEM_EDGES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .frameClk(frameClk), .emphCtrlIn(emphCtrlIn),
    .intBitClkMode(intBitClkMode), .cmd(cmd), .stat(stat),
    .ratioCode(ratioCode), .ratioErr(ratioErr), .deemphEn(deemphEn)
  );

  ratio_seq_ctrl #(
    .REF_CYCLES(REF_CYCLES), .CONV_CYCLES(CONV_CYCLES), .MUTE_FRAMES(MUTE_FRAMES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .stat(stat), .cmd(cmd),
    .refEn(refEn), .convEn(convEn), .modRstN(modRstN), .audioUnmute(audioUnmute)
  );

endmodule

// File: rtl/mclk_ratio_sequencer_chk.sv
module mclk_ratio_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       intBitClkMode,
  input logic [3:0] ratioCode,
  input logic       ratioErr,
  input logic       refEn,
  input logic       convEn,
  input logic       audioUnmute,
  input logic       deemphEn
);

  p_code_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    refEn |-> (ratioCode != 4'd0 && ratioCode <= 4'd10));

  p_err_powered_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ratioErr |-> !refEn);

  p_conv_after_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
    convEn |-> refEn);

  p_unmute_needs_conv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    audioUnmute |-> convEn);

  p_unmute_from_conv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(audioUnmute) |-> $past(convEn));

  p_deemph_set_internal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deemphEn) |-> $past(intBitClkMode));

  p_ext_no_deemph_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !intBitClkMode |=> !deemphEn);

endmodule

bind mclk_ratio_sequencer mclk_ratio_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .intBitClkMode(intBitClkMode),
  .ratioCode(ratioCode), .ratioErr(ratioErr), .refEn(refEn), .convEn(convEn),
  .audioUnmute(audioUnmute), .deemphEn(deemphEn)
);

// File: tb/sim_mclk_ratio_sequencer.sv
module sim_mclk_ratio_sequencer;

  localparam int TOL   = 2;
  localparam int LOSS  = 1400;
  localparam int REFC  = 20;
  localparam int CONVC = 30;
  localparam int MUTEF = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frameClk = 1'b0;
  logic       emphCtrlIn = 1'b1;
  logic       intBitClkMode = 1'b1;
  logic [3:0] ratioCode;
  logic       ratioErr, refEn, convEn, modRstN, audioUnmute, deemphEn;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  mclk_ratio_sequencer #(
    .TOL(TOL), .LOSS_LIMIT(LOSS), .DEM_EDGES(5),
    .REF_CYCLES(REFC), .CONV_CYCLES(CONVC), .MUTE_FRAMES(MUTEF)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .frameClk(frameClk), .emphCtrlIn(emphCtrlIn),
    .intBitClkMode(intBitClkMode), .ratioCode(ratioCode), .ratioErr(ratioErr),
    .refEn(refEn), .convEn(convEn), .modRstN(modRstN),
    .audioUnmute(audioUnmute), .deemphEn(deemphEn)
  );

  // edge time stamps, sampled on the falling clock edge
  int  cyc = 0;
  int  tRef = -1, tConv = -1, tUn = -1;
  logic pRef = 1'b0, pConv = 1'b0, pUn = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (refEn && !pRef)        tRef  = cyc;
    if (convEn && !pConv)      tConv = cyc;
    if (audioUnmute && !pUn)   tUn   = cyc;
    pRef = refEn; pConv = convEn; pUn = audioUnmute;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frames(input int p, input int n);
    for (int f = 0; f < n; f++) begin
      frameClk = 1'b1;
      repeat (p / 2) @(negedge clk);
      frameClk = 1'b0;
      repeat (p - p / 2) @(negedge clk);
    end
  endtask

  task automatic dropClock();
    frameClk = 1'b0;
    repeat (LOSS + 40) @(negedge clk);
    check(refEn == 0 && convEn == 0 && modRstN == 0 && audioUnmute == 0,
          "R7 enables off", {refEn, convEn, modRstN, audioUnmute}, 0);
    check(ratioCode == 0, "R7 code cleared", ratioCode, 0);
    check(ratioErr == 0, "R7 error cleared", ratioErr, 0);
  endtask

  function automatic int ratioVal(input int i);
    if (i == 9) return 1152;
    return ((i % 2 == 0) ? 64 : 96) << (i / 2);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(refEn == 0 && convEn == 0 && modRstN == 0 && audioUnmute == 0,
          "R1 enables in reset", {refEn, convEn, modRstN, audioUnmute}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ratioCode == 0 && ratioErr == 0 && deemphEn == 0,
          "R1 code/err/deemph after reset", {ratioCode, ratioErr, deemphEn}, 0);

    repeat (300) @(negedge clk);
    check(refEn == 0 && ratioCode == 0, "R2 idle without frame clock",
          {refEn, ratioCode}, 0);

    // sweep every ratio at lower edge, centre and upper edge (R3, R10)
    for (int i = 0; i < 10; i++) begin
      int off, p, d;
      off = ((i % 3) - 1) * TOL;
      p   = ratioVal(i) + off;
      tRef = -1; tConv = -1; tUn = -1;
      frames(p, 8);
      check(ratioCode == 4'(i + 1), (off != 0) ? "R10 edge lock code" : "R3 lock code",
            ratioCode, i + 1);
      check(ratioErr == 0, "R3 no error on lock", ratioErr, 0);
      check(tRef > 0 && tConv - tRef == REFC, "R5 reference lead time", tConv - tRef, REFC);
      check(modRstN == convEn, "R5 reset release with converter", modRstN, convEn);
      d = tUn - tConv;
      check(tUn > 0 && d >= CONVC + (MUTEF - 1) * p && d <= CONVC + MUTEF * p + 4,
            "R6 unmute delay", d, CONVC + MUTEF * p);
      check(audioUnmute && refEn && convEn, "R6 running state",
            {audioUnmute, refEn, convEn}, 7);
      dropClock();
    end

    // between two ratios
    frames(80, 6);
    check(ratioErr == 1, "R4 error between ratios", ratioErr, 1);
    check(refEn == 0 && ratioCode == 0, "R4 stays down", {refEn, ratioCode}, 0);
    dropClock();

    // one beyond the tolerance edge
    frames(64 + TOL + 1, 6);
    check(ratioErr == 1, "R10 just outside window", ratioErr, 1);
    check(refEn == 0 && ratioCode == 0, "R4 outside window stays down",
          {refEn, ratioCode}, 0);
    dropClock();

    // de-emphasis filter, internal mode (R8)
    emphCtrlIn = 1'b1;
    frames(64, 3);
    emphCtrlIn = 1'b0;
    frames(64, 4);
    check(deemphEn == 0, "R8 four lows not enough", deemphEn, 0);
    frames(64, 1);
    check(deemphEn == 1, "R8 five lows set", deemphEn, 1);
    emphCtrlIn = 1'b1;
    frames(64, 4);
    check(deemphEn == 1, "R8 four highs not enough", deemphEn, 1);
    frames(64, 1);
    check(deemphEn == 0, "R8 five highs clear", deemphEn, 0);
    emphCtrlIn = 1'b0;
    frames(64, 3);
    emphCtrlIn = 1'b1;
    frames(64, 1);
    emphCtrlIn = 1'b0;
    frames(64, 4);
    check(deemphEn == 0, "R8 broken run ignored", deemphEn, 0);
    frames(64, 1);
    check(deemphEn == 1, "R8 fresh run of five sets", deemphEn, 1);

    // external mode (R9)
    intBitClkMode = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(deemphEn == 0, "R9 external mode clears", deemphEn, 0);
    frames(64, 6);
    check(deemphEn == 0, "R9 pin ignored in external mode", deemphEn, 0);
    intBitClkMode = 1'b1;
    frames(64, 4);
    check(deemphEn == 0, "R9 history restarted", deemphEn, 0);
    frames(64, 1);
    check(deemphEn == 1, "R9 five lows after return", deemphEn, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule